// File: doc/BRIEF.md
# Chunked Outbound Address Window Decoder

This block sits beside a host-to-PCI bridge and answers two address questions in the same cycle. For a processor-side address it says whether the address falls inside an enabled 8 MiB chunk of the forwardable top region, which starts at 0xF0000000, and so must be passed on to PCI. It also reports which chunk that is. For an address driven by a PCI bus master it gives a two-bit region code that tells the master-side path where the access lands.

Two 32-bit configuration words are held inside the block. The mode word gates all forwarding through a two-bit field. The window word carries one enable bit per chunk. Both are loaded through single-cycle write strobes. A loaded value steers the combinational decoders from the cycle after its strobe. The chunk at the bottom of the range and the chunk at the top are reserved for boot firmware and for the bridge's own registers, so they are never forwarded whatever the window word holds.

Top module: `outbound_window_decoder`

## Requirements
- R1: After reset both configuration words are zero, so no processor address hits.
- R2: A processor address below 0xF0000000 never hits, and its reported chunk index is 0.
- R3: For an address A at or above 0xF0000000, the reported chunk index is A[27:23]. The address hits exactly when the mode field is 01 and window bit A[27:23] is 1.
- R4: Chunk 0 (0xF0000000 to 0xF07FFFFF) and chunk 31 (0xFF800000 to 0xFFFFFFFF) never hit, even when their window bits are set.
- R5: The mode field is bits [8:7] of the mode word. The values 00, 10 and 11 disable every chunk. No other bit of the mode word has any effect.
- R6: A value written with a strobe steers the outputs from the cycle after the strobe's clock edge, and not during the strobe cycle. Without a strobe the stored value holds.
- R7: A bus-master address below 0xF0800000 gives region code 01 (system memory).
- R8: A bus-master address from 0xF0800000 to 0xFF7FFFFF (30 chunks) gives region code 10 (PCI memory).
- R9: A bus-master address from 0xFFF00000 to 0xFFFFFFFE gives region code 11 (processor local).
- R10: A bus-master address from 0xFF800000 to 0xFFEFFFFF, or equal to 0xFFFFFFFF, gives region code 00 (miss).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_wr | input | 1 | Load strobe for the mode word |
| mode_wdata | input | 32 | New mode word; bits [8:7] are the forwarding mode |
| win_wr | input | 1 | Load strobe for the window word |
| win_wdata | input | 32 | New window word, one enable bit per chunk |
| cpu_addr | input | 32 | Processor-side address to decode |
| cpu_hit | output | 1 | Address must be forwarded to PCI |
| cpu_chunk | output | 5 | Chunk index of the address, 0 when outside the range |
| bm_addr | input | 32 | Bus-master address to classify |
| bm_region | output | 2 | 00 miss, 01 system memory, 10 PCI memory, 11 processor local |

## Verification
On every cycle, assertions check these properties. No hit is raised below the window base or on either reserved chunk. The top bus-master address always misses, and the low bus-master addresses always map to system memory. A mode strobe sets the forwarding gate one edge later, and the window enables stay unchanged when there is no strobe. The bench scenarios cover the rest. They show the exact region boundaries on both sides of each limit and that mode values 00, 10 and 11 shut every chunk. They also show that unrelated mode bits do nothing and that the outputs still reflect the old configuration during the strobe cycle itself.

// File: rtl/owd_pkg.sv
package owd_pkg;

    localparam int DATA_W = 32;

    typedef enum logic [1:0] {
        RGN_MISS   = 2'b00,
        RGN_SYSMEM = 2'b01,
        RGN_PCIMEM = 2'b10,
        RGN_LOCAL  = 2'b11
    } region_e;

    typedef struct packed {
        logic [DATA_W-1:0] mode;
        logic [DATA_W-1:0] win;
    } cfg_t;

endpackage

// File: rtl/owd_cfg_regs.sv
module owd_cfg_regs
    import owd_pkg::*;
#(
    parameter int NUM_CHUNKS = 32,
    parameter int MODE_LSB   = 7
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  mode_wr,
    input  logic [DATA_W-1:0]     mode_wdata,
    input  logic                  win_wr,
    input  logic [DATA_W-1:0]     win_wdata,
    output logic                  fwd_en,
    output logic [NUM_CHUNKS-1:0] chunk_en
);

    localparam logic [1:0] MODE_FWD = 2'b01;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (mode_wr) cfg_d.mode = mode_wdata;
        if (win_wr)  cfg_d.win  = win_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign fwd_en = (cfg_q.mode[MODE_LSB +: 2] == MODE_FWD);

    // The bottom and top chunks are reserved and stay dark.
    for (genvar i = 0; i < NUM_CHUNKS; i++) begin : g_chunk
        if (i == 0 || i == NUM_CHUNKS - 1) begin : g_reserved
            assign chunk_en[i] = 1'b0;
        end else begin : g_open
            assign chunk_en[i] = cfg_q.win[i];
        end
    end

    AST_MODE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr |=> (fwd_en == ($past(mode_wdata[MODE_LSB +: 2]) == MODE_FWD))); // R6
    AST_WIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !win_wr |=> $stable(chunk_en)); // R6

endmodule

// File: rtl/owd_cpu_decode.sv
module owd_cpu_decode #(
    parameter int                ADDR_W     = 32,
    parameter int                CHUNK_SH   = 23,
    parameter int                NUM_CHUNKS = 32,
    parameter logic [ADDR_W-1:0] WIN_BASE   = 32'hF000_0000
) (
    input  logic [ADDR_W-1:0]             addr,
    input  logic                          fwd_en,
    input  logic [NUM_CHUNKS-1:0]         chunk_en,
    output logic                          hit,
    output logic [$clog2(NUM_CHUNKS)-1:0] chunk
);

    localparam int              IDX_W   = $clog2(NUM_CHUNKS);
    localparam int              EW      = ADDR_W + 1;
    localparam logic [EW-1:0]   WIN_END = {1'b0, WIN_BASE} + (EW'(NUM_CHUNKS) << CHUNK_SH);

    logic              in_range;
    logic [ADDR_W-1:0] offset;

    always_comb begin
        in_range = ({1'b0, addr} >= {1'b0, WIN_BASE}) && ({1'b0, addr} < WIN_END);
        offset   = addr - WIN_BASE;
        chunk    = in_range ? offset[CHUNK_SH +: IDX_W] : '0;
        hit      = in_range && fwd_en && chunk_en[chunk];
    end

endmodule

// File: rtl/owd_master_classify.sv
module owd_master_classify
    import owd_pkg::*;
#(
    parameter int                ADDR_W     = 32,
    parameter int                CHUNK_SH   = 23,
    parameter int                PCI_CHUNKS = 30,
    parameter logic [ADDR_W-1:0] WIN_BASE   = 32'hF000_0000,
    parameter logic [ADDR_W-1:0] LOCAL_LO   = 32'hFFF0_0000,
    parameter logic [ADDR_W-1:0] LOCAL_HI   = 32'hFFFF_FFFE
) (
    input  logic [ADDR_W-1:0] addr,
    output region_e           region
);

    localparam int            EW     = ADDR_W + 1;
    localparam logic [EW-1:0] PCI_LO = {1'b0, WIN_BASE} + (EW'(1) << CHUNK_SH);
    localparam logic [EW-1:0] PCI_HI = PCI_LO + (EW'(PCI_CHUNKS) << CHUNK_SH);

    logic [EW-1:0] a_ext;

    always_comb begin
        a_ext = {1'b0, addr};
        if (a_ext < PCI_LO)
            region = RGN_SYSMEM;
        else if (a_ext < PCI_HI)
            region = RGN_PCIMEM;
        else if (addr >= LOCAL_LO && addr <= LOCAL_HI)
            region = RGN_LOCAL;
        else
            region = RGN_MISS;
    end

endmodule

// File: rtl/outbound_window_decoder.sv
module outbound_window_decoder
    import owd_pkg::*;
#(
    parameter int                ADDR_W     = 32,
    parameter int                CHUNK_SH   = 23,
    parameter int                NUM_CHUNKS = 32,
    parameter int                MODE_LSB   = 7,
    parameter logic [ADDR_W-1:0] WIN_BASE   = 32'hF000_0000,
    parameter logic [ADDR_W-1:0] LOCAL_LO   = 32'hFFF0_0000,
    parameter logic [ADDR_W-1:0] LOCAL_HI   = 32'hFFFF_FFFE
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          mode_wr,
    input  logic [DATA_W-1:0]             mode_wdata,
    input  logic                          win_wr,
    input  logic [DATA_W-1:0]             win_wdata,
    input  logic [ADDR_W-1:0]             cpu_addr,
    output logic                          cpu_hit,
    output logic [$clog2(NUM_CHUNKS)-1:0] cpu_chunk,
    input  logic [ADDR_W-1:0]             bm_addr,
    output logic [1:0]                    bm_region
);

    localparam int                PCI_CHUNKS = NUM_CHUNKS - 2;
    localparam logic [ADDR_W-1:0] PCI_LO     = WIN_BASE + (ADDR_W'(1) << CHUNK_SH);

    logic                  fwd_en;
    logic [NUM_CHUNKS-1:0] chunk_en;
    region_e               region;

    owd_cfg_regs #(
        .NUM_CHUNKS (NUM_CHUNKS),
        .MODE_LSB   (MODE_LSB)
    ) cfg_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_wr    (mode_wr),
        .mode_wdata (mode_wdata),
        .win_wr     (win_wr),
        .win_wdata  (win_wdata),
        .fwd_en     (fwd_en),
        .chunk_en   (chunk_en)
    );

    owd_cpu_decode #(
        .ADDR_W     (ADDR_W),
        .CHUNK_SH   (CHUNK_SH),
        .NUM_CHUNKS (NUM_CHUNKS),
        .WIN_BASE   (WIN_BASE)
    ) cpu_i (
        .addr     (cpu_addr),
        .fwd_en   (fwd_en),
        .chunk_en (chunk_en),
        .hit      (cpu_hit),
        .chunk    (cpu_chunk)
    );

    owd_master_classify #(
        .ADDR_W     (ADDR_W),
        .CHUNK_SH   (CHUNK_SH),
        .PCI_CHUNKS (PCI_CHUNKS),
        .WIN_BASE   (WIN_BASE),
        .LOCAL_LO   (LOCAL_LO),
        .LOCAL_HI   (LOCAL_HI)
    ) bm_i (
        .addr   (bm_addr),
        .region (region)
    );

    assign bm_region = region;

    AST_NO_HIT_BELOW_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr < WIN_BASE) |-> !cpu_hit); // R2
    AST_RESERVED_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_hit |-> (cpu_chunk != '0 && cpu_chunk != '1)); // R4
    AST_BM_LOW_SYSMEM: assert property (@(posedge clk) disable iff (!rst_n)
        (bm_addr < PCI_LO) |-> (bm_region == RGN_SYSMEM)); // R7
    AST_BM_TOP_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        (bm_addr == '1) |-> (bm_region == RGN_MISS)); // R10

endmodule

// File: tb/outbound_window_decoder_tb.sv
module outbound_window_decoder_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_wr = 1'b0;
    logic [31:0] mode_wdata = '0;
    logic        win_wr = 1'b0;
    logic [31:0] win_wdata = '0;
    logic [31:0] cpu_addr = '0;
    logic        cpu_hit;
    logic [4:0]  cpu_chunk;
    logic [31:0] bm_addr = '0;
    logic [1:0]  bm_region;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] m_mode = '0;
    logic [31:0] m_win = '0;

    string       q_tag[$];
    logic        q_hit[$];
    logic [4:0]  q_chunk[$];
    logic [1:0]  q_rgn[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    outbound_window_decoder dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_wr    (mode_wr),
        .mode_wdata (mode_wdata),
        .win_wr     (win_wr),
        .win_wdata  (win_wdata),
        .cpu_addr   (cpu_addr),
        .cpu_hit    (cpu_hit),
        .cpu_chunk  (cpu_chunk),
        .bm_addr    (bm_addr),
        .bm_region  (bm_region)
    );

    function automatic logic [4:0] exp_chunk(input logic [31:0] a);
        return (a >= 32'hF000_0000) ? a[27:23] : 5'd0;
    endfunction

    function automatic logic exp_hit(input logic [31:0] md, input logic [31:0] wn,
                                     input logic [31:0] a);
        logic [4:0] c;
        c = exp_chunk(a);
        return (a >= 32'hF000_0000) && (md[8:7] == 2'b01) && wn[c] &&
               (c != 5'd0) && (c != 5'd31);
    endfunction

    function automatic logic [1:0] exp_rgn(input logic [31:0] a);
        if (a < 32'hF080_0000) return 2'b01;
        if (a <= 32'hFF7F_FFFF) return 2'b10;
        if (a >= 32'hFFF0_0000 && a != 32'hFFFF_FFFF) return 2'b11;
        return 2'b00;
    endfunction

    // Driver: one stimulus per cycle; pushes the value expected after the edge.
    task automatic drive(input string tag, input logic mw, input logic [31:0] md,
                         input logic ww, input logic [31:0] wd,
                         input logic [31:0] ca, input logic [31:0] ba);
        logic old_hit;
        @(negedge clk);
        mode_wr = mw; mode_wdata = md;
        win_wr  = ww; win_wdata  = wd;
        cpu_addr = ca; bm_addr = ba;
        old_hit = exp_hit(m_mode, m_win, ca);
        if (mw || ww) begin
            #1;
            checks++;
            if (cpu_hit !== old_hit) begin
                errors++;
                $display("FAIL R6 pre-edge hit: actual %0b expected %0b", cpu_hit, old_hit);
            end
        end
        if (mw) m_mode = md;
        if (ww) m_win = wd;
        q_tag.push_back(tag);
        q_hit.push_back(exp_hit(m_mode, m_win, ca));
        q_chunk.push_back(exp_chunk(ca));
        q_rgn.push_back(exp_rgn(ba));
    endtask

    // Monitor: samples a quarter period after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_PERIOD/4);
            if (q_tag.size() > 0) begin
                string      t;
                logic       h;
                logic [4:0] c;
                logic [1:0] r;
                t = q_tag.pop_front();
                h = q_hit.pop_front();
                c = q_chunk.pop_front();
                r = q_rgn.pop_front();
                checks++;
                if (cpu_hit !== h || cpu_chunk !== c || bm_region !== r) begin
                    errors++;
                    $display("FAIL %s: actual hit=%0b chunk=%0d rgn=%0d expected hit=%0b chunk=%0d rgn=%0d",
                             t, cpu_hit, cpu_chunk, bm_region, h, c, r);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state: nothing hits
        drive("R1 reset", 0, 0, 0, 0, 32'hF080_0000, 32'h0000_0000);
        drive("R1 reset", 0, 0, 0, 0, 32'hF800_0000, 32'h1234_5678);
        // R6 configuration takes effect after the strobe edge
        drive("R6 mode load", 1, 32'h0000_0080, 0, 0, 32'hF080_0000, 32'hF07F_FFFF);
        drive("R6 win load", 0, 0, 1, 32'hFFFF_FFFF, 32'hF080_0000, 32'hF080_0000);
        // R3 and R4 with every window bit set
        drive("R3 chunk1", 0, 0, 0, 0, 32'hF080_0000, 32'hFF7F_FFFF);
        drive("R3 chunk30", 0, 0, 0, 0, 32'hFF7F_FFFF, 32'hFF80_0000);
        drive("R4 chunk0", 0, 0, 0, 0, 32'hF000_0000, 32'hFFEF_FFFF);
        drive("R4 chunk0 top", 0, 0, 0, 0, 32'hF07F_FFFF, 32'hFFF0_0000);
        drive("R4 chunk31", 0, 0, 0, 0, 32'hFF80_0000, 32'hFFFF_FFFE);
        drive("R4 chunk31 top", 0, 0, 0, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        // R2 below the window
        drive("R2 below base", 0, 0, 0, 0, 32'hEFFF_FFFF, 32'h8000_0000);
        // R3 a single enabled chunk
        drive("R3 single", 0, 0, 1, 32'h0000_0004, 32'hF100_0000, 32'hF080_0000);
        drive("R3 neighbour", 0, 0, 0, 0, 32'hF180_0000, 32'hF100_0000);
        drive("R3 enabled mid", 0, 0, 0, 0, 32'hF17F_FFFC, 32'h0);
        // R5 mode gating
        drive("R5 mode00", 1, 32'hFFFF_FE7F, 0, 0, 32'hF100_0000, 32'h0);
        drive("R5 mode10", 1, 32'h0000_0100, 0, 0, 32'hF100_0000, 32'h0);
        drive("R5 mode11", 1, 32'h0000_0180, 0, 0, 32'hF100_0000, 32'h0);
        drive("R5 mode01 other bits", 1, 32'hFFFF_FEFF, 0, 0, 32'hF100_0000, 32'h0);
        // R6 window clear takes effect after edge
        drive("R6 win clear", 0, 0, 1, 32'h0, 32'hF100_0000, 32'h0);
        drive("R6 hold", 0, 0, 0, 0, 32'hF100_0000, 32'h0);
        // R7..R10 master boundaries
        drive("R7 sys low", 0, 0, 0, 0, 32'h0, 32'hF07F_FFFF);
        drive("R8 pci low", 0, 0, 0, 0, 32'h0, 32'hF080_0000);
        drive("R8 pci high", 0, 0, 0, 0, 32'h0, 32'hFF7F_FFFF);
        drive("R10 gap low", 0, 0, 0, 0, 32'h0, 32'hFF80_0000);
        drive("R10 gap high", 0, 0, 0, 0, 32'h0, 32'hFFEF_FFFF);
        drive("R9 local low", 0, 0, 0, 0, 32'h0, 32'hFFF0_0000);
        drive("R9 local high", 0, 0, 0, 0, 32'h0, 32'hFFFF_FFFE);
        drive("R10 top", 0, 0, 0, 0, 32'h0, 32'hFFFF_FFFF);
        drive("R7 idle", 0, 0, 0, 0, 32'h0, 32'h0);
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule